// File: doc/BRIEF.md
# RF Packet Deframer and Checker

This block sits behind a byte-oriented UART receiver on a low-cost radio link. The transmitter sends each packet in a fixed order. First come warm-up bytes that let the analog slicer settle. Next comes an alignment pair: a byte of all ones followed by a byte of all zeros. After that come a fixed number of payload bytes, each XOR-whitened with 10101010 to keep the line near 50% duty cycle. A single checksum byte closes the packet.

The deframer hunts the incoming byte stream for the alignment pair and ignores everything before it. It then strips the whitening from each payload byte and hands the byte on with a valid strobe and a last flag. It computes the checksum on its own and compares it with the received one. Every packet it opens ends with exactly one status pulse, good or bad. A UART framing error or an overlong silence between bytes aborts the packet.

Top module: `rf_deframer`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `out_valid`, `out_last`, `pkt_good` and `pkt_bad` are all low.
- R2: While hunting, bytes that are not part of an alignment pair (for example 8'hAA warm-up bytes) produce no output and no status pulse.
- R3: A packet opens only when a byte 8'hFF is immediately followed by a byte 8'h00. If an 8'hFF is followed by any value other than 8'h00 or 8'hFF, hunting restarts, so a later lone 8'h00 opens nothing.
- R4: Any run of consecutive 8'hFF bytes keeps the deframer waiting, and the 8'h00 that follows the run opens a packet.
- R5: Each of the PAYLOAD_LEN bytes after the alignment pair appears on `out_data` as the received byte XOR 8'hAA, with `out_valid` high for one clock, on the clock after the byte is accepted.
- R6: `out_last` is high together with `out_valid` for payload byte PAYLOAD_LEN-1 only.
- R7: The byte after the payload is the checksum. When it equals 8'hFF minus the modulo-256 sum of the received (still whitened) payload bytes, `pkt_good` pulses for one clock on the clock after that byte is accepted. Carries out of bit 7 are dropped.
- R8: When the checksum byte does not match, `pkt_bad` pulses for one clock in place of `pkt_good`.
- R9: `in_frame_err` high during a packet (payload or checksum phase) aborts it. No data is output for that cycle, and `pkt_bad` pulses on the next clock.
- R10: During a packet, GAP_LIMIT consecutive clocks without `in_valid` abort it. `pkt_bad` pulses on the clock after the GAP_LIMIT-th idle clock. Shorter gaps have no effect.
- R11: After any packet ends (good, bad or aborted) the deframer hunts again, so bytes that follow produce nothing until a new alignment pair arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Received byte present this clock |
| in_data | input | 8 | Received byte from the UART |
| in_frame_err | input | 1 | UART framing error pulse |
| out_valid | output | 1 | De-whitened payload byte valid |
| out_data | output | 8 | De-whitened payload byte |
| out_last | output | 1 | Marks the final payload byte |
| pkt_good | output | 1 | Packet checksum matched (one clock) |
| pkt_bad | output | 1 | Packet failed or was aborted (one clock) |

## Verification
Payload output and status pulses each come one clock after the input cycle that causes them. A timeout pulse comes one clock after the GAP_LIMIT-th idle clock. The bench drives inputs on falling edges and queues the expected results in order. The monitor compares every output event at the next falling edge, so each result is matched against the cycle in which it is due. An output with nothing queued is flagged as spurious, and a queue that is not empty after a short drain is flagged as a missing result. The timeout is also checked at the exact edge: no pulse one idle clock early, and a pulse exactly when due.

// File: rtl/rfdf_pkg.sv
package rfdf_pkg;

    localparam logic [7:0] ALIGN_HI   = 8'hFF;
    localparam logic [7:0] ALIGN_LO   = 8'h00;
    localparam logic [7:0] WHITEN_KEY = 8'hAA;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_BODY,
        ST_CHECK
    } df_state_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
        logic       last;
    } df_beat_t;

    typedef struct packed {
        logic good;
        logic bad;
    } df_status_t;

    function automatic logic [7:0] dewhiten(input logic [7:0] b);
        return b ^ WHITEN_KEY;
    endfunction

    function automatic logic [7:0] expected_check(input logic [7:0] s);
        return 8'hFF - s;
    endfunction

endpackage

// File: rtl/rfdf_align_hunter.sv
module rfdf_align_hunter
    import rfdf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       byte_valid,
    input  logic       byte_err,
    input  logic [7:0] byte_data,
    output logic       found
);
    logic armed;

    always_comb begin
        found = enable && armed && byte_valid && !byte_err && (byte_data == ALIGN_LO);
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            armed <= 1'b0;
        end else if (byte_err) begin
            armed <= 1'b0;
        end else if (byte_valid) begin
            // a run of ones keeps the hunter armed; anything else disarms
            armed <= (byte_data == ALIGN_HI);
        end
    end
endmodule

// File: rtl/rfdf_gap_timer.sv
module rfdf_gap_timer #(
    parameter int GAP_LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic byte_seen,
    output logic expired
);
    localparam int CW = $clog2(GAP_LIMIT + 1);
    localparam logic [CW-1:0] LAST_IDLE = CW'(GAP_LIMIT - 1);

    logic [CW-1:0] idle_cnt;

    always_comb begin
        expired = active && !byte_seen && (idle_cnt == LAST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst || !active || byte_seen) begin
            idle_cnt <= '0;
        end else if (idle_cnt != LAST_IDLE) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rfdf_sum_acc.sv
module rfdf_sum_acc (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       add,
    input  logic [7:0] data,
    output logic [7:0] sum
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sum <= '0;
        end else if (add) begin
            sum <= sum + data;
        end
    end
endmodule

// File: rtl/rf_deframer.sv
module rf_deframer
    import rfdf_pkg::*;
#(
    parameter int PAYLOAD_LEN = 4,
    parameter int GAP_LIMIT   = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_frame_err,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last,
    output logic       pkt_good,
    output logic       pkt_bad
);
    localparam int IW = (PAYLOAD_LEN > 1) ? $clog2(PAYLOAD_LEN) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(PAYLOAD_LEN - 1);

    df_state_e  state;
    logic [IW-1:0] idx;
    df_beat_t   beat;
    df_status_t status;

    logic       in_packet;
    logic       found;
    logic       gap_expired;
    logic       abort;
    logic       body_take;
    logic [7:0] run_sum;

    always_comb begin
        in_packet = (state != ST_HUNT);
        abort     = in_packet && (in_frame_err || gap_expired);
        body_take = (state == ST_BODY) && in_valid && !abort;
    end

    rfdf_align_hunter u_hunt (
        .clk       (clk),
        .rst       (rst),
        .enable    (state == ST_HUNT),
        .byte_valid(in_valid),
        .byte_err  (in_frame_err),
        .byte_data (in_data),
        .found     (found)
    );

    rfdf_gap_timer #(.GAP_LIMIT(GAP_LIMIT)) u_gap (
        .clk      (clk),
        .rst      (rst),
        .active   (in_packet),
        .byte_seen(in_valid),
        .expired  (gap_expired)
    );

    rfdf_sum_acc u_sum (
        .clk  (clk),
        .rst  (rst),
        .clear(found),
        .add  (body_take),
        .data (in_data),
        .sum  (run_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_HUNT;
            idx    <= '0;
            beat   <= '0;
            status <= '0;
        end else begin
            beat.valid <= 1'b0;
            beat.last  <= 1'b0;
            status     <= '0;
            unique case (state)
                ST_HUNT: begin
                    if (found) begin
                        state <= ST_BODY;
                        idx   <= '0;
                    end
                end
                ST_BODY: begin
                    if (abort) begin
                        status.bad <= 1'b1;
                        state      <= ST_HUNT;
                    end else if (in_valid) begin
                        beat.valid <= 1'b1;
                        beat.data  <= dewhiten(in_data);
                        beat.last  <= (idx == LAST_IDX);
                        if (idx == LAST_IDX) begin
                            state <= ST_CHECK;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_CHECK: begin
                    if (abort) begin
                        status.bad <= 1'b1;
                        state      <= ST_HUNT;
                    end else if (in_valid) begin
                        if (in_data == expected_check(run_sum)) begin
                            status.good <= 1'b1;
                        end else begin
                            status.bad <= 1'b1;
                        end
                        state <= ST_HUNT;
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end

    assign out_valid = beat.valid;
    assign out_data  = beat.data;
    assign out_last  = beat.last;
    assign pkt_good  = status.good;
    assign pkt_bad   = status.bad;

endmodule

// File: rtl/rfdf_checker.sv
module rfdf_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [7:0] in_data,
    input logic       in_frame_err,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       out_last,
    input logic       pkt_good,
    input logic       pkt_bad
);
    // R7 R8: a packet ends with one verdict only
    a_r8_single_verdict: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pkt_good, pkt_bad}));

    // R6: the last flag only travels with a data beat
    a_r6_last_with_valid: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    // R5: a data beat is the previous clock's byte with whitening removed
    a_r5_dewhiten: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(in_valid) && !$past(in_frame_err)
                       && out_data == ($past(in_data) ^ 8'hAA)));

    // R7: a good verdict follows an accepted checksum byte
    a_r7_good_after_byte: assert property (@(posedge clk) disable iff (rst)
        pkt_good |-> ($past(in_valid) && !$past(in_frame_err)));

    // R9: a framing error never yields a data beat or a good verdict
    a_r9_err_no_good: assert property (@(posedge clk) disable iff (rst)
        $past(in_frame_err) |-> (!out_valid && !pkt_good));

    // R11: data and verdict never share a clock
    a_r11_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && (pkt_good || pkt_bad)));
endmodule

bind rf_deframer rfdf_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_frame_err(in_frame_err),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_last    (out_last),
    .pkt_good    (pkt_good),
    .pkt_bad     (pkt_bad)
);

// File: tb/sim_rf_deframer.sv
module sim_rf_deframer;
    localparam int N   = 4;
    localparam int GAP = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_frame_err = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_last;
    logic       pkt_good;
    logic       pkt_bad;

    always #4 clk = ~clk;

    rf_deframer #(.PAYLOAD_LEN(N), .GAP_LIMIT(GAP)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_frame_err(in_frame_err), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .pkt_good(pkt_good), .pkt_bad(pkt_bad)
    );

    typedef struct {
        int         kind;   // 0 data, 1 good, 2 bad
        logic [7:0] data;
        logic       last;
        string      req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    logic [7:0] pl [N];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic expect_data(input logic [7:0] d, input logic l, input string r);
        exp_t e;
        e.kind = 0; e.data = d; e.last = l; e.req = r;
        q.push_back(e);
    endtask

    task automatic expect_status(input int k, input string r);
        exp_t e;
        e.kind = k; e.data = 8'h00; e.last = 1'b0; e.req = r;
        q.push_back(e);
    endtask

    // called on a falling edge, returns on the next one
    task automatic send_byte(input logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_body(input bit corrupt, input int gap, input string r);
        logic [7:0] sum;
        logic [7:0] w;
        logic [7:0] ck;
        sum = 8'h00;
        for (int i = 0; i < N; i++) begin
            w = pl[i] ^ 8'hAA;
            sum = sum + w;
            expect_data(pl[i], (i == N - 1), r);
            send_byte(w);
            repeat (gap) @(negedge clk);
        end
        ck = 8'hFF - sum;
        if (corrupt) ck = ck ^ 8'h01;
        expect_status(corrupt ? 2 : 1, r);
        send_byte(ck);
    endtask

    task automatic drain(input string r);
        repeat (4) @(negedge clk);
        check(q.size() == 0, r, "missing results", q.size(), 0);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && (out_valid || pkt_good || pkt_bad)) begin
            if (q.size() == 0) begin
                check(1'b0, "R2", "unexpected output",
                      {out_valid, pkt_good, pkt_bad}, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (e.kind == 0) begin
                    check(out_valid && !pkt_good && !pkt_bad, e.req, "beat kind",
                          {out_valid, pkt_good, pkt_bad}, 3'b100);
                    check(out_data == e.data, "R5", "payload byte", out_data, e.data);
                    check(out_last == e.last, "R6", "last flag", out_last, e.last);
                end else if (e.kind == 1) begin
                    check(pkt_good && !pkt_bad && !out_valid, e.req, "good pulse",
                          {out_valid, pkt_good, pkt_bad}, 3'b010);
                end else begin
                    check(pkt_bad && !pkt_good && !out_valid, e.req, "bad pulse",
                          {out_valid, pkt_good, pkt_bad}, 3'b001);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs idle under reset
        check({out_valid, out_last, pkt_good, pkt_bad} == 4'b0, "R1", "reset outputs",
              {out_valid, out_last, pkt_good, pkt_bad}, 0);
        rst = 1'b0;
        @(negedge clk);
        check({out_valid, out_last, pkt_good, pkt_bad} == 4'b0, "R1", "after reset",
              {out_valid, out_last, pkt_good, pkt_bad}, 0);

        // R2 R3 R5 R6 R7: warm-up then clean packet
        repeat (3) send_byte(8'hAA);
        send_byte(8'h12); send_byte(8'h00);
        drain("R2");
        send_byte(8'hFF); send_byte(8'h00);
        pl[0] = 8'h01; pl[1] = 8'h7E; pl[2] = 8'hC3; pl[3] = 8'h55;
        send_body(1'b0, 0, "R7");
        drain("R7");

        // R8: corrupted checksum
        send_byte(8'hAA); send_byte(8'hFF); send_byte(8'h00);
        pl[0] = 8'h10; pl[1] = 8'h20; pl[2] = 8'h30; pl[3] = 8'h40;
        send_body(1'b1, 0, "R8");
        drain("R8");

        // R4: a run of ones before the zeros byte
        send_byte(8'hFF); send_byte(8'hFF); send_byte(8'hFF); send_byte(8'h00);
        pl[0] = 8'hAA; pl[1] = 8'h00; pl[2] = 8'hFF; pl[3] = 8'h99;
        send_body(1'b0, 0, "R4");
        drain("R4");

        // R3: ones byte broken by another value, lone zeros byte opens nothing
        send_byte(8'hFF); send_byte(8'h55); send_byte(8'h00);
        send_byte(8'h31); send_byte(8'h32); send_byte(8'h33); send_byte(8'h34);
        send_byte(8'h35);
        drain("R3");

        // R7: checksum sum wraps past 255
        send_byte(8'hFF); send_byte(8'h00);
        pl[0] = 8'h55; pl[1] = 8'h54; pl[2] = 8'h53; pl[3] = 8'h52;
        send_body(1'b0, 0, "R7");
        drain("R7");

        // R10: gaps just short of the limit are tolerated
        send_byte(8'hFF); send_byte(8'h00);
        pl[0] = 8'h0F; pl[1] = 8'hF0; pl[2] = 8'h3C; pl[3] = 8'hC3;
        send_body(1'b0, GAP - 1, "R10");
        drain("R10");

        // R9 R11: framing error mid-payload, then leftovers are ignored
        send_byte(8'hFF); send_byte(8'h00);
        expect_data(8'h11, 1'b0, "R9"); send_byte(8'h11 ^ 8'hAA);
        expect_data(8'h22, 1'b0, "R9"); send_byte(8'h22 ^ 8'hAA);
        expect_status(2, "R9");
        in_frame_err = 1'b1;
        @(negedge clk);
        in_frame_err = 1'b0;
        drain("R9");
        send_byte(8'h33 ^ 8'hAA); send_byte(8'h44 ^ 8'hAA); send_byte(8'h5A);
        drain("R11");

        // R10: timeout after one byte, checked at the exact clock
        send_byte(8'hFF); send_byte(8'h00);
        expect_data(8'h66, 1'b0, "R10"); send_byte(8'h66 ^ 8'hAA);
        expect_status(2, "R10");
        repeat (GAP - 1) @(negedge clk);
        check(pkt_bad == 1'b0, "R10", "early timeout", pkt_bad, 0);
        @(negedge clk);
        check(pkt_bad == 1'b1, "R10", "timeout pulse", pkt_bad, 1);
        drain("R10");

        // R11: clean packet after the abort
        send_byte(8'h77); send_byte(8'hFF); send_byte(8'h00);
        pl[0] = 8'hDE; pl[1] = 8'hAD; pl[2] = 8'hBE; pl[3] = 8'hEF;
        send_body(1'b0, 1, "R11");
        send_byte(8'h12); send_byte(8'h34);
        drain("R11");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule